// File: doc/BRIEF.md
# Phase-Selectable Card Clock Generator

This block makes the card clock for an SD/eMMC host and the two sampling strobes that go with it. It runs in a single system clock domain. Each of its two reference sources arrives as a one-cycle enable: a crystal reference and a PLL-derived reference. The selected source is divided by an integer N to give a quadrant tick. A two-bit quadrant counter advances on every tick. One full card clock period is four quadrants, which is 4N source enables. The card clock is high for two quadrants and low for two.

A 32-bit control register holds four kinds of setting: the divide value, the source select, a core phase that places the card clock edges on the quadrant counter, and separate transmit and receive phases. Each of the two phases places a one-cycle strobe on one quadrant edge. Two configuration inputs control stopping. A stop-clock bit parks the clock. An always-on bit keeps the clock running while no transfer is active. Without that bit, the clock runs only while `xfer_active` is high.

Stopping waits for a falling card-clock edge, so a high pulse is never cut short. The block captures the register's settings only while the clock is parked. Phase and divide changes therefore act only across a stop and restart.

The controller has three states:
- ST_PARK: the clock is held low and settings are captured every cycle.
- ST_RUN: the clock is toggling.
- ST_DRAIN: a hold request is pending and the clock is toggling until its next low quadrant.

The transitions are:
- PARK->RUN, on release: the hold request is low and the register's divide value is nonzero.
- RUN->DRAIN, on hold.
- DRAIN->RUN, on release while draining.
- DRAIN->PARK, on the falling tick: a quadrant tick whose new clock level is low.

Top module: `cardclk_gen`

## Requirements
- R1: After reset the control register reads 0x0000_023F: divide 63, crystal source, core phase code 2, transmit and receive phase code 0. A write replaces all 32 bits, and the new value is read back the next cycle.
- R2: With divide value N in bits [5:0], the card clock period is 4N enables of the selected source, with 2N of them high.
- R3: Source select bits [7:6] equal to 1 count the PLL enable. Codes 0, 2 and 3 count the crystal enable.
- R4: Phase codes 0..3 mean 0, 90, 180 and 270 degrees. The card clock rises on the tick that brings the quadrant counter to the core phase code in bits [9:8].
- R5: The transmit strobe is a one-cycle pulse, once per card period. It occurs on the tick that brings the quadrant counter to the code in bits [11:10]. Let rel be (tx - core) mod 4. For rel 0 it coincides with the rising edge, for 1 it falls mid-high, for 2 it coincides with the falling edge, and for 3 it falls mid-low.
- R6: The receive strobe follows the same rule as R5, using bits [13:12].
- R7: Divide, source and phase values written while the clock is running have no effect until the clock has parked and restarted.
- R8: While `cfg_stop_clk` is high, the clock finishes its current high phase and then parks low. No high pulse is shorter than 2N source enables.
- R9: With `cfg_clk_always_on` low, the clock parks while `xfer_active` is low and runs while it is high. With `cfg_clk_always_on` high, it runs regardless of `xfer_active`.
- R10: A divide value of 0 keeps the clock parked and low. Writing a nonzero value then starts it.
- R11: On restart, the first rising edge comes N source enables after the controller leaves the parked state. The clock is low for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register contents |
| cfg_stop_clk | input | 1 | Park the card clock |
| cfg_clk_always_on | input | 1 | Keep the clock running while idle |
| xfer_active | input | 1 | A transfer is in progress |
| ref_xtal_en | input | 1 | Crystal reference enable pulse |
| ref_pll_en | input | 1 | PLL-derived reference enable pulse |
| card_clk | output | 1 | Divided card clock |
| tx_strobe | output | 1 | Transmit launch strobe |
| rx_strobe | output | 1 | Receive sample strobe |

## Verification
The bench keeps the default six-bit divide field and drives the crystal enable high on every cycle. With that source, one source enable equals one system clock, so periods, high times and restart delays become exact cycle counts. The PLL enable toggles every cycle, which gives a known factor of two. Small divide values (1 to 3) make it cheap to sweep all 64 core, transmit and receive phase combinations. The reset value of 63 and a stop applied at every offset within a period cover the largest divide and each point at which a stop can land.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
    localparam int DIV_W    = 6;
    localparam int SRC_W    = 2;
    localparam int PH_W     = 2;
    localparam int CTRL_W   = 32;
    localparam int DIV_LSB  = 0;
    localparam int SRC_LSB  = DIV_LSB + DIV_W;
    localparam int CORE_LSB = SRC_LSB + SRC_W;
    localparam int TX_LSB   = CORE_LSB + PH_W;
    localparam int RX_LSB   = TX_LSB + PH_W;
    localparam logic [SRC_W-1:0] SRC_PLL = 2'd1;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_023F;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
        logic [PH_W-1:0]  core;
        logic [PH_W-1:0]  tx;
        logic [PH_W-1:0]  rx;
    } clk_set_t;

    function automatic clk_set_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        clk_set_t s;
        s.div  = w[DIV_LSB  +: DIV_W];
        s.src  = w[SRC_LSB  +: SRC_W];
        s.core = w[CORE_LSB +: PH_W];
        s.tx   = w[TX_LSB   +: PH_W];
        s.rx   = w[RX_LSB   +: PH_W];
        return s;
    endfunction
endpackage

// File: rtl/cardclk_ctrl_reg.sv
module cardclk_ctrl_reg
    import cardclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output clk_set_t          fields
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= CTRL_RESET;
        else if (we)
            rdata <= wdata;
    end

    assign fields = unpack_ctrl(rdata);
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel_pll,
    input  logic             ref0_en,
    input  logic             ref1_en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             src_en;

    assign src_en = sel_pll ? ref1_en : ref0_en;
    assign tick   = run && src_en && (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (src_en)
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/cardclk_phase_fsm.sv
module cardclk_phase_fsm
    import cardclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_req,
    input  clk_set_t   reg_set,
    input  logic       tick,
    output gen_state_e state,
    output clk_set_t   act_set,
    output logic       card_clk,
    output logic       tx_stb,
    output logic       rx_stb
);
    gen_state_e      state_d;
    logic [PH_W-1:0] quad_q;
    logic [PH_W-1:0] quad_n;
    logic [PH_W-1:0] rel_n;
    logic            lvl_n;

    assign quad_n = quad_q + PH_W'(1);
    assign rel_n  = quad_n - act_set.core;
    assign lvl_n  = ~rel_n[PH_W-1];

    always_comb begin
        state_d = state;
        unique case (state)
            ST_PARK:  if (!hold_req && reg_set.div != '0) state_d = ST_RUN;
            ST_RUN:   if (hold_req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!hold_req)
                    state_d = ST_RUN;
                else if (tick && !lvl_n)
                    state_d = ST_PARK;
            end
            default:  state_d = ST_PARK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_PARK;
        else
            state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_set  <= unpack_ctrl(CTRL_RESET);
            quad_q   <= '0;
            card_clk <= 1'b0;
            tx_stb   <= 1'b0;
            rx_stb   <= 1'b0;
        end else if (state == ST_PARK) begin
            act_set  <= reg_set;
            card_clk <= 1'b0;
            tx_stb   <= 1'b0;
            rx_stb   <= 1'b0;
            if (state_d == ST_RUN)
                quad_q <= reg_set.core - PH_W'(1);
        end else if (tick) begin
            quad_q   <= quad_n;
            card_clk <= lvl_n;
            tx_stb   <= (quad_n == act_set.tx);
            rx_stb   <= (quad_n == act_set.rx);
        end else begin
            tx_stb   <= 1'b0;
            rx_stb   <= 1'b0;
        end
    end
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              cfg_stop_clk,
    input  logic              cfg_clk_always_on,
    input  logic              xfer_active,
    input  logic              ref_xtal_en,
    input  logic              ref_pll_en,
    output logic              card_clk,
    output logic              tx_strobe,
    output logic              rx_strobe
);
    clk_set_t   reg_set;
    clk_set_t   act_set;
    gen_state_e st;
    logic       tick;
    logic       hold_req;

    assign hold_req = cfg_stop_clk | (~cfg_clk_always_on & ~xfer_active);

    cardclk_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (ctrl_wdata),
        .rdata  (ctrl_rdata),
        .fields (reg_set)
    );

    cardclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st != ST_PARK),
        .sel_pll (act_set.src == SRC_PLL),
        .ref0_en (ref_xtal_en),
        .ref1_en (ref_pll_en),
        .div     (act_set.div),
        .tick    (tick)
    );

    cardclk_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .reg_set  (reg_set),
        .tick     (tick),
        .state    (st),
        .act_set  (act_set),
        .card_clk (card_clk),
        .tx_stb   (tx_strobe),
        .rx_stb   (rx_strobe)
    );
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk
    import cardclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input gen_state_e st,
    input logic       tick,
    input logic       card_clk,
    input logic       tx_stb,
    input logic       rx_stb,
    input clk_set_t   act,
    input clk_set_t   reg_set
);
    a_r8_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARK) |-> !card_clk);

    a_r2_edge_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(card_clk) |-> $past(tick));

    a_r5_tx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> $past(tick));

    a_r6_rx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> $past(tick));

    a_r7_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_PARK) |=> $stable(act));

    a_r10_div0_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARK && reg_set.div == '0) |=> (st == ST_PARK));
endmodule

bind cardclk_gen cardclk_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .tick     (tick),
    .card_clk (card_clk),
    .tx_stb   (tx_strobe),
    .rx_stb   (rx_strobe),
    .act      (act_set),
    .reg_set  (reg_set)
);

// File: tb/tb_cardclk_gen.sv
module tb_cardclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        cfg_stop_clk = 1'b0;
    logic        cfg_clk_always_on = 1'b0;
    logic        xfer_active = 1'b0;
    logic        ref_xtal_en = 1'b1;
    logic        ref_pll_en = 1'b0;
    logic        card_clk;
    logic        tx_strobe;
    logic        rx_strobe;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    cardclk_gen dut (.*);

    initial forever begin
        @(negedge clk);
        ref_pll_en = ~ref_pll_en;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input int n, input int src, input int core,
                                        input int tx, input int rx);
        return 32'((rx << 12) | (tx << 10) | (core << 8) | (src << 6) | n);
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // park, write new settings, release; returns negedges until first rise
    task automatic reconfig(input logic [31:0] w, input int wt, output int k);
        cfg_clk_always_on = 1'b1;
        cfg_stop_clk = 1'b1;
        repeat (wt) @(negedge clk);
        wr(w);
        cfg_stop_clk = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!card_clk);
    endtask

    task automatic lvl_chk(input string tag, input int ph, input int core,
                           input bit prev, input bit cur);
        int rel, e;
        rel = (ph - core) & 3;
        e = ((rel == 1 || rel == 2) ? 2 : 0) + ((rel == 0 || rel == 1) ? 1 : 0);
        chk((prev * 2 + cur) == e, tag, prev * 2 + cur, e);
    endtask

    task automatic measure(input int n, input int src, input int core,
                           input int tx, input int rx);
        int p, cnt, hi, txs, rxs;
        bit prev;
        p = 4 * n * ((src == 1) ? 2 : 1);
        @(negedge clk);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        prev = 1'b1; cnt = 0; hi = 0; txs = 0; rxs = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (card_clk) hi++;
            if (tx_strobe) begin txs++; lvl_chk("R4 R5 tx level", tx, core, prev, card_clk); end
            if (rx_strobe) begin rxs++; lvl_chk("R4 R6 rx level", rx, core, prev, card_clk); end
            if (!prev && card_clk) break;
            prev = card_clk;
        end
        chk(cnt == p, "R2 R3 period", cnt, p);
        chk(hi == p / 2, "R2 high time", hi, p / 2);
        chk(txs == 1, "R5 tx count", txs, 1);
        chk(rxs == 1, "R6 rx count", rxs, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int k, hilen, highs;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R9 idle gating with always-on clear
        @(negedge clk);
        chk(ctrl_rdata == 32'h0000_023F, "R1 reset value", int'(ctrl_rdata), 32'h23F);
        highs = 0;
        repeat (40) begin @(negedge clk); if (card_clk || tx_strobe || rx_strobe) highs++; end
        chk(highs == 0, "R9 idle parked", highs, 0);
        // R11 + R1 reset settings: divide 63, core 180
        cfg_clk_always_on = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!card_clk);
        chk(k == 64, "R11 restart delay", k, 64);
        measure(63, 0, 2, 0, 0);
        // R4 R5 R6 full phase sweep
        for (int n = 1; n <= 3; n++)
            for (int ph = 0; ph < 64; ph++) begin
                reconfig(mkw(n, 0, ph & 3, (ph >> 2) & 3, ph >> 4), 300, k);
                chk(k == n + 1, "R11 restart delay", k, n + 1);
                chk(ctrl_rdata == mkw(n, 0, ph & 3, (ph >> 2) & 3, ph >> 4), "R1 readback",
                    int'(ctrl_rdata), int'(mkw(n, 0, ph & 3, (ph >> 2) & 3, ph >> 4)));
                measure(n, 0, ph & 3, (ph >> 2) & 3, ph >> 4);
            end
        // R3 source select
        reconfig(mkw(1, 1, 0, 1, 3), 60, k); measure(1, 1, 0, 1, 3);
        reconfig(mkw(2, 1, 3, 0, 2), 60, k); measure(2, 1, 3, 0, 2);
        reconfig(mkw(2, 2, 1, 1, 2), 60, k); measure(2, 2, 1, 1, 2);
        reconfig(mkw(3, 3, 0, 0, 0), 60, k); measure(3, 3, 0, 0, 0);
        // R7 writes while running are ignored until park
        reconfig(mkw(2, 0, 0, 0, 2), 60, k);
        wr(mkw(5, 1, 2, 3, 1));
        measure(2, 0, 0, 0, 2);
        reconfig(mkw(5, 1, 2, 3, 1), 60, k);
        measure(5, 1, 2, 3, 1);
        // R8 stop at every offset within a period; no short high pulse
        for (int off = 0; off < 12; off++) begin
            reconfig(mkw(3, 0, 0, 0, 0), 60, k);
            hilen = 1; prev = 1'b1; highs = 0;
            for (int c = 0; c < 70; c++) begin
                @(negedge clk);
                if (c == off) cfg_stop_clk = 1'b1;
                if (card_clk) begin
                    hilen++;
                    if (c >= 40) highs++;
                end else begin
                    if (prev) chk(hilen == 6, "R8 high pulse width", hilen, 6);
                    hilen = 0;
                end
                prev = card_clk;
            end
            chk(highs == 0 && !card_clk, "R8 parked low", highs, 0);
            cfg_stop_clk = 1'b0;
        end
        // R9 transfer-driven running
        reconfig(mkw(2, 0, 0, 0, 0), 60, k);
        cfg_clk_always_on = 1'b0;
        xfer_active = 1'b1;
        measure(2, 0, 0, 0, 0);
        xfer_active = 1'b0;
        repeat (30) @(negedge clk);
        highs = 0;
        repeat (50) begin @(negedge clk); if (card_clk) highs++; end
        chk(highs == 0, "R9 idle parks", highs, 0);
        cfg_clk_always_on = 1'b1;
        measure(2, 0, 0, 0, 0);
        // R10 divide zero holds low, nonzero write restarts
        cfg_stop_clk = 1'b1;
        repeat (60) @(negedge clk);
        wr(mkw(0, 0, 0, 0, 0));
        cfg_stop_clk = 1'b0;
        highs = 0;
        repeat (200) begin @(negedge clk); if (card_clk || tx_strobe) highs++; end
        chk(highs == 0, "R10 zero divide low", highs, 0);
        wr(mkw(2, 0, 1, 1, 3));
        measure(2, 0, 1, 1, 3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule